// File: doc/BRIEF.md
# Two-Output Interrupt Router

This block gathers up to 32 interrupt sources and combines them onto two upstream request lines, `irq0_o` and `irq1_o`. Each source has its own configuration bits. A route bit picks the output line. An enable bit gates the source. A type bit selects level or edge detection. A polarity bit inverts the input before detection. Software programs these bits and observes the result through a 32-bit register port. Reads return data one cycle after the address is presented.

Edge sources latch a pending bit on an active transition and hold it until software writes a one to that bit in the raw-status register. Level sources have no latch: their pending bit tracks the polarity-adjusted input. Each output has its own status word, formed as pending AND enable AND route. An output line is asserted, one cycle later, whenever its status word is nonzero. A security word per source is stored and read back, but it is not enforced anywhere.

Top module: `irq_split_router`

## Requirements
- R1: After a synchronous reset, the route, enable, type, polarity, security and pending bits are all zero, and both request outputs are low.
- R2: A route bit of 0 sends the source to output 0 (status at 0x1C, `irq0_o`). A route bit of 1 sends it to output 1 (status at 0x20, `irq1_o`). The route word is at 0x00.
- R3: A write to 0x04 loads the enable word directly, and a read of 0x04 returns it. A source whose enable bit is 0 does not appear in either status word.
- R4: Writing ones to 0x08 clears the matching enable bits, and writing ones to 0x0C sets them. Zero bits leave the enable bits unchanged. Reads of 0x08 and 0x0C return zero.
- R5: The type word at 0x10 uses 1 for edge and 0 for level. An edge source sets its pending bit on an active transition, and the bit stays set after the input returns to inactive.
- R6: The polarity word at 0x14 uses 1 for active-low and 0 for active-high.
- R7: The pending bit of a level source equals the polarity-adjusted input, sampled one clock earlier. Clear writes have no effect on it.
- R8: Writing ones to 0x24 clears the matching edge pending bits. Zero bits leave them unchanged.
- R9: When an active edge and a clear of the same bit fall in the same cycle, the pending bit stays set.
- R10: A read of 0x24 returns the pending word regardless of enable. A read of 0x1C returns pending & enable & ~route, and a read of 0x20 returns pending & enable & route.
- R11: Each request output is a register. It goes high the cycle after its status word becomes nonzero and low the cycle after the word becomes zero.
- R12: Writes to 0x1C and 0x20 are ignored.
- R13: The security word at 0x18 reads back as written and has no effect on routing or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered one cycle after the address |
| src_in | input | 32 | Interrupt source inputs |
| irq0_o | output | 1 | Combined request for sources routed to 0 |
| irq1_o | output | 1 | Combined request for sources routed to 1 |

## Verification
Two functions can meet in one cycle: a new active edge on a source, and a software clear of that same source's pending bit. The bench provokes this by driving the rising source input in the same cycle as a raw-status write carrying a one in that bit. It then judges the outcome by reading raw status, which must still show the bit set. Separate steps confirm that a clear with no coinciding edge does empty the bit, and that clears do nothing to level sources.

// File: rtl/irq_split_pkg.sv
package irq_split_pkg;
  localparam int REG_DW = 32;
  localparam int REG_AW = 6;
  typedef logic [REG_AW-1:0] regaddr_t;
  localparam regaddr_t A_ROUTE = 6'h00;
  localparam regaddr_t A_ENABLE = 6'h04;
  localparam regaddr_t A_ENCLR = 6'h08;
  localparam regaddr_t A_ENSET = 6'h0C;
  localparam regaddr_t A_TYPE = 6'h10;
  localparam regaddr_t A_POL = 6'h14;
  localparam regaddr_t A_SEC = 6'h18;
  localparam regaddr_t A_STAT0 = 6'h1C;
  localparam regaddr_t A_STAT1 = 6'h20;
  localparam regaddr_t A_RAW = 6'h24;
endpackage

// File: rtl/irq_split_cfg.sv
module irq_split_cfg
  import irq_split_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  regaddr_t          addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [NSRC-1:0]   sel_q,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   typ_q,
  output logic [NSRC-1:0]   pol_q,
  output logic [NSRC-1:0]   sec_q,
  output logic [NSRC-1:0]   clr
);
  logic [NSRC-1:0] wd;
  assign wd  = wdata[NSRC-1:0];
  assign clr = (we && addr == A_RAW) ? wd : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      en_q  <= '0;
      typ_q <= '0;
      pol_q <= '0;
      sec_q <= '0;
    end else if (we) begin
      case (addr)
        A_ROUTE:  sel_q <= wd;
        A_ENABLE: en_q  <= wd;
        A_ENCLR:  en_q  <= en_q & ~wd;
        A_ENSET:  en_q  <= en_q | wd;
        A_TYPE:   typ_q <= wd;
        A_POL:    pol_q <= wd;
        A_SEC:    sec_q <= wd;
        default:  ;
      endcase
    end
  end

  // R4: write-one set and clear act only on the marked bits
  p_enset_r4: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_ENSET) |=> ((en_q & $past(wd)) == $past(wd)));
  p_enclr_r4: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_ENCLR) |=> ((en_q & $past(wd)) == '0));
endmodule

// File: rtl/irq_split_pend.sv
module irq_split_pend #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] typ,
  input  logic [NSRC-1:0] pol,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend_q
);
  logic [NSRC-1:0] adj;
  logic [NSRC-1:0] adj_q;
  logic [NSRC-1:0] rise;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign adj[g]  = src_in[g] ^ pol[g];
    assign rise[g] = adj[g] & ~adj_q[g];
    always_ff @(posedge clk) begin
      if (rst) begin
        adj_q[g]  <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        adj_q[g] <= adj[g];
        if (typ[g]) pend_q[g] <= rise[g] | (pend_q[g] & ~clr[g]);
        else        pend_q[g] <= adj[g];
      end
    end
  end

  // R7: level bits mirror the adjusted input of the previous cycle
  p_level_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (typ != '1) |=> (((pend_q ^ $past(adj)) & ~$past(typ)) == '0));
  // R5: an edge on an edge source always leaves its bit set
  p_edge_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (|(rise & typ)) |=> ((~pend_q & $past(rise & typ)) == '0));
  // R8: a clear with no coinciding edge empties the bit
  p_edge_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (|(typ & clr & ~rise)) |=> ((pend_q & $past(typ & clr & ~rise)) == '0));
  // R9: an edge coinciding with a clear wins
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (|(typ & clr & rise)) |=> ((~pend_q & $past(typ & clr & rise)) == '0));
endmodule

// File: rtl/irq_split_router.sv
module irq_split_router
  import irq_split_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic              irq0_o,
  output logic              irq1_o
);
  logic [NSRC-1:0] sel_q, en_q, typ_q, pol_q, sec_q, clr, pend_q;
  logic [NSRC-1:0] stat0, stat1;

  irq_split_cfg #(.NSRC(NSRC)) u_cfg (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .sel_q(sel_q), .en_q(en_q), .typ_q(typ_q), .pol_q(pol_q), .sec_q(sec_q),
    .clr(clr)
  );

  irq_split_pend #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .src_in(src_in), .typ(typ_q), .pol(pol_q),
    .clr(clr), .pend_q(pend_q)
  );

  assign stat0 = pend_q & en_q & ~sel_q;
  assign stat1 = pend_q & en_q & sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq0_o    <= 1'b0;
      irq1_o    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq0_o <= |stat0;
      irq1_o <= |stat1;
      case (reg_addr)
        A_ROUTE:  reg_rdata <= REG_DW'(sel_q);
        A_ENABLE: reg_rdata <= REG_DW'(en_q);
        A_TYPE:   reg_rdata <= REG_DW'(typ_q);
        A_POL:    reg_rdata <= REG_DW'(pol_q);
        A_SEC:    reg_rdata <= REG_DW'(sec_q);
        A_STAT0:  reg_rdata <= REG_DW'(stat0);
        A_STAT1:  reg_rdata <= REG_DW'(stat1);
        A_RAW:    reg_rdata <= REG_DW'(pend_q);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R11: with nothing enabled neither request can rise
  p_irq_needs_enable_r11: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> (!irq0_o && !irq1_o));
endmodule

// File: tb/irq_split_router_bench.sv
`timescale 1ns/1ps
module irq_split_router_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] src = '0;
  logic irq0, irq1;
  int checks = 0;
  int errors = 0;

  typedef struct { string tag; logic [31:0] exp; } item_t;
  item_t sb[$];
  logic [31:0] obs;
  event smp_ev;

  always #5 clk = ~clk;

  irq_split_router u_irq_split_router (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .src_in(src), .irq0_o(irq0), .irq1_o(irq1)
  );

  // monitor: pops expected items and compares them to observed values
  initial forever begin
    @(smp_ev);
    checks++;
    if (sb.size() == 0) begin
      errors++;
      $display("FAIL scoreboard empty act=%h", obs);
    end else begin
      item_t it;
      it = sb.pop_front();
      if (obs !== it.exp) begin
        errors++;
        $display("FAIL %s act=%h exp=%h", it.tag, obs, it.exp);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    item_t it;
    it.tag = t; it.exp = e;
    sb.push_back(it);
    @(posedge clk); #1;
    addr = a;
    @(posedge clk); #1;
    obs = rdata;
    -> smp_ev;
  endtask

  task automatic irq_chk(input logic [1:0] e, input string t);
    item_t it;
    it.tag = t; it.exp = {30'b0, e};
    sb.push_back(it);
    @(posedge clk); #1;
    @(posedge clk); #1;
    obs = {30'b0, irq1, irq0};
    -> smp_ev;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(posedge clk); #1;
    src = v;
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    rd(6'h00, 32'h0, "R1 route");
    rd(6'h04, 32'h0, "R1 enable");
    rd(6'h10, 32'h0, "R1 type");
    rd(6'h14, 32'h0, "R1 polarity");
    rd(6'h18, 32'h0, "R1 security");
    rd(6'h24, 32'h0, "R1 raw");
    irq_chk(2'b00, "R1 outputs");
    // R3, R4 enable handling
    wr(6'h04, 32'h0000_00F0);
    rd(6'h04, 32'h0000_00F0, "R3 enable load");
    wr(6'h08, 32'h0000_0030);
    rd(6'h04, 32'h0000_00C0, "R4 enable clear");
    wr(6'h0C, 32'h0000_0003);
    rd(6'h04, 32'h0000_00C3, "R4 enable set");
    rd(6'h0C, 32'h0, "R4 set address reads zero");
    // R2, R10, R11 routing of level sources
    wr(6'h00, 32'h0000_0002);
    rd(6'h00, 32'h0000_0002, "R2 route readback");
    set_src(32'h1);
    rd(6'h1C, 32'h1, "R2 status0 source0");
    rd(6'h20, 32'h0, "R2 status1 empty");
    irq_chk(2'b01, "R11 irq0 only");
    set_src(32'h2);
    rd(6'h20, 32'h2, "R2 status1 source1");
    irq_chk(2'b10, "R11 irq1 only");
    set_src(32'h4);
    rd(6'h24, 32'h4, "R10 raw ignores enable");
    rd(6'h1C, 32'h0, "R3 disabled absent status0");
    irq_chk(2'b00, "R11 none enabled pending");
    // R7 level not affected by clear
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h24, 32'h4, "R7 level survives clear");
    set_src(32'h0);
    rd(6'h24, 32'h0, "R7 level follows input");
    // R6 polarity
    wr(6'h14, 32'h0000_0008);
    rd(6'h14, 32'h0000_0008, "R6 polarity readback");
    rd(6'h24, 32'h8, "R6 low input active");
    set_src(32'h8);
    rd(6'h24, 32'h0, "R6 high input inactive");
    set_src(32'h0);
    wr(6'h14, 32'h0);
    rd(6'h24, 32'h0, "R6 polarity restored");
    // R5 edge latch
    wr(6'h10, 32'h1);
    rd(6'h10, 32'h1, "R5 type readback");
    set_src(32'h1);
    set_src(32'h0);
    rd(6'h24, 32'h1, "R5 edge latched");
    irq_chk(2'b01, "R11 edge drives irq0");
    // R12 status writes ignored
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    rd(6'h24, 32'h1, "R12 raw unchanged");
    rd(6'h1C, 32'h1, "R12 status0 unchanged");
    rd(6'h00, 32'h2, "R12 route unchanged");
    // R8 clear
    wr(6'h24, 32'hFFFF_FFFE);
    rd(6'h24, 32'h1, "R8 zero bit keeps pending");
    wr(6'h24, 32'h1);
    rd(6'h24, 32'h0, "R8 one bit clears");
    irq_chk(2'b00, "R11 irq0 drops");
    // R9 edge and clear in the same cycle
    set_src(32'h1);
    set_src(32'h0);
    @(posedge clk); #1;
    we = 1'b1; addr = 6'h24; wdata = 32'h1; src = 32'h1;
    @(posedge clk); #1;
    we = 1'b0;
    rd(6'h24, 32'h1, "R9 edge wins over clear");
    set_src(32'h0);
    wr(6'h24, 32'h1);
    rd(6'h24, 32'h0, "R9 later clear works");
    // R13 security
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, 32'hFFFF_FFFF, "R13 security readback");
    set_src(32'h2);
    rd(6'h20, 32'h2, "R13 routing unchanged");
    rd(6'h1C, 32'h0, "R13 status0 unchanged");
    irq_chk(2'b10, "R13 irq1 unchanged");
    // R3 disable via clear
    wr(6'h08, 32'h2);
    rd(6'h04, 32'h0000_00C1, "R4 single bit cleared");
    rd(6'h20, 32'h0, "R3 disabled leaves status1");
    rd(6'h24, 32'h2, "R10 raw still pending");
    irq_chk(2'b00, "R11 irq1 drops");
    @(posedge clk);
    @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule